// File: doc/BRIEF.md
# Per-Pin Output-Enable Router

This block sits between the macrocell logic and the pads of a programmable logic device. It builds a small bank of global output-enable lines from a shared set of candidate sources. Each line can take either polarity of a source. Each pad then picks one of those lines, or a hard off or hard on setting, as its tri-state control. Each pad can also be set to open-drain, where it only ever pulls low.

Two feedback paths leave the block for every pad. The pin path returns the level on the pad. The macrocell path returns the macrocell's own output. Because the two paths do not depend on each other, a pad used as an input still leaves its macrocell free for buried logic.

A programming-mode input takes every pad off the bus. All configuration arrives as static input vectors, so the block has no stream data path and every pin is a plain level.

Top module: `ioc_top`

## Requirements
- R1: A pad whose 3-bit enable select is 6 never drives (pad_oe low), so the pad acts as a dedicated input.
- R2: A pad whose enable select is 7 drives permanently (pad_oe high) unless programming mode or open-drain release applies.
- R3: A pad whose enable select is a value g from 0 to 5 uses global enable line g as its tri-state control.
- R4: On each rising clock edge, global line g loads its chosen source XOR its invert bit. The source is chosen by its 3-bit code: codes 0 and 1 pick oe_in[0] and oe_in[1], codes 2 and 3 pick pad_in[0] and pad_in[1], codes 4 and 5 pick mc_data[0] and mc_data[1], and codes 6 and 7 pick constant 0.
- R5: While rst_n is low, every global line is 0, so pads that select a global line do not drive.
- R6: With open-drain set, pad_out is 0 and pad_oe is the pad's enable AND NOT mc_data, so a high level is left to the pull-up.
- R7: With open-drain clear, pad_out equals mc_data.
- R8: While prog_mode is high, every pad_oe is low.
- R9: pin_fb always equals pad_in and mc_fb always equals mc_data, whatever the enable select and open-drain settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the global enable registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | Forces every pad enable off |
| oe_in | input | 2 | Dedicated output-enable input pins |
| mc_data | input | N_PIN | Macrocell output for each pad |
| pad_in | input | N_PIN | Level seen on each pad |
| goe_src_sel | input | 18 | 3-bit source code for each of the six global lines |
| goe_inv | input | 6 | Invert bit for each global line |
| pin_oe_sel | input | 3*N_PIN | 3-bit enable select for each pad |
| pin_od | input | N_PIN | Open-drain enable for each pad |
| pad_out | output | N_PIN | Data driven to each pad |
| pad_oe | output | N_PIN | Tri-state enable for each pad |
| pin_fb | output | N_PIN | Feedback of the pad level |
| mc_fb | output | N_PIN | Feedback of the macrocell output |

## Verification
Some pad rules are checked on every cycle, for every pad:
- the off select never drives (R1);
- a global-line select follows that line (R3);
- an open-drain pad never drives high (R6);
- programming mode releases everything (R8);
- both feedback paths stay independent (R9).

Other behaviour only the bench scenarios can show, since it involves the resolved pad level:
- global line loading, including the constant codes and the invert bit (R4);
- the reset value (R5);
- the pull-up reaching a released or open-drain pad, and an external driver being read back through pin feedback.

// File: rtl/ioc_pkg.sv
`timescale 1ns/1ps
package ioc_pkg;
  localparam int SEL_W   = 3;
  localparam int N_GOE   = 6;
  localparam int N_OEIN  = 2;
  localparam int N_PSRC  = 2;
  localparam int N_MSRC  = 2;
  localparam int N_SRC   = 1 << SEL_W;
  localparam logic [SEL_W-1:0] PIN_SEL_OFF = 3'd6;
  localparam logic [SEL_W-1:0] PIN_SEL_ON  = 3'd7;
endpackage

// File: rtl/ioc_goe_bank.sv
`timescale 1ns/1ps
module ioc_goe_bank
  import ioc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_OEIN-1:0]      oe_in,
  input  logic [N_PSRC-1:0]      pad_src,
  input  logic [N_MSRC-1:0]      mc_src,
  input  logic [N_GOE*SEL_W-1:0] src_sel,
  input  logic [N_GOE-1:0]       inv,
  output logic [N_GOE-1:0]       goe_q
);
  localparam int N_USED = N_OEIN + N_PSRC + N_MSRC;

  logic [N_SRC-1:0] src_vec;
  logic [N_GOE-1:0] goe_d;

  always_comb begin
    src_vec = '0;
    src_vec[N_USED-1:0] = {mc_src, pad_src, oe_in};
  end

  for (genvar g = 0; g < N_GOE; g++) begin : g_line
    always_comb goe_d[g] = src_vec[src_sel[g*SEL_W +: SEL_W]] ^ inv[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) goe_q[g] <= 1'b0;
      else        goe_q[g] <= goe_d[g];
    end
  end
endmodule

// File: rtl/ioc_pin_cell.sv
`timescale 1ns/1ps
module ioc_pin_cell
  import ioc_pkg::*;
(
  input  logic             mc_data,
  input  logic             pad_in,
  input  logic [N_GOE-1:0] goe,
  input  logic [SEL_W-1:0] oe_sel,
  input  logic             od_en,
  input  logic             prog_mode,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pin_fb,
  output logic             mc_fb
);
  logic en_raw;

  always_comb begin
    if (oe_sel == PIN_SEL_ON)       en_raw = 1'b1;
    else if (oe_sel == PIN_SEL_OFF) en_raw = 1'b0;
    else                            en_raw = goe[oe_sel];
  end

  always_comb begin
    if (od_en) begin
      pad_out = 1'b0;
      pad_oe  = en_raw & ~mc_data & ~prog_mode;
    end else begin
      pad_out = mc_data;
      pad_oe  = en_raw & ~prog_mode;
    end
    pin_fb = pad_in;
    mc_fb  = mc_data;
  end
endmodule

// File: rtl/ioc_top.sv
`timescale 1ns/1ps
module ioc_top
  import ioc_pkg::*;
#(
  parameter int N_PIN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_mode,
  input  logic [N_OEIN-1:0]      oe_in,
  input  logic [N_PIN-1:0]       mc_data,
  input  logic [N_PIN-1:0]       pad_in,
  input  logic [N_GOE*SEL_W-1:0] goe_src_sel,
  input  logic [N_GOE-1:0]       goe_inv,
  input  logic [N_PIN*SEL_W-1:0] pin_oe_sel,
  input  logic [N_PIN-1:0]       pin_od,
  output logic [N_PIN-1:0]       pad_out,
  output logic [N_PIN-1:0]       pad_oe,
  output logic [N_PIN-1:0]       pin_fb,
  output logic [N_PIN-1:0]       mc_fb
);
  logic [N_GOE-1:0] goe_q;

  ioc_goe_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .oe_in   (oe_in),
    .pad_src (pad_in[N_PSRC-1:0]),
    .mc_src  (mc_data[N_MSRC-1:0]),
    .src_sel (goe_src_sel),
    .inv     (goe_inv),
    .goe_q   (goe_q)
  );

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    ioc_pin_cell u_cell (
      .mc_data   (mc_data[i]),
      .pad_in    (pad_in[i]),
      .goe       (goe_q),
      .oe_sel    (pin_oe_sel[i*SEL_W +: SEL_W]),
      .od_en     (pin_od[i]),
      .prog_mode (prog_mode),
      .pad_out   (pad_out[i]),
      .pad_oe    (pad_oe[i]),
      .pin_fb    (pin_fb[i]),
      .mc_fb     (mc_fb[i])
    );
  end
endmodule

// File: rtl/ioc_checker.sv
`timescale 1ns/1ps
module ioc_checker
  import ioc_pkg::*;
#(
  parameter int N_PIN = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   prog_mode,
  input logic [N_PIN-1:0]       mc_data,
  input logic [N_PIN-1:0]       pad_in,
  input logic [N_PIN*SEL_W-1:0] pin_oe_sel,
  input logic [N_PIN-1:0]       pin_od,
  input logic [N_PIN-1:0]       pad_out,
  input logic [N_PIN-1:0]       pad_oe,
  input logic [N_PIN-1:0]       pin_fb,
  input logic [N_PIN-1:0]       mc_fb,
  input logic [N_GOE-1:0]       goe_q
);
  assert_prog_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |-> (pad_oe == '0));

  for (genvar i = 0; i < N_PIN; i++) begin : g_chk
    assert_input_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe_sel[i*SEL_W +: SEL_W] == PIN_SEL_OFF) |-> !pad_oe[i]);

    assert_follow_global_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_mode && !pin_od[i] && pin_oe_sel[i*SEL_W +: SEL_W] < 3'(N_GOE))
        |-> (pad_oe[i] == goe_q[pin_oe_sel[i*SEL_W +: SEL_W]]));

    assert_never_drive_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_od[i] && pad_oe[i]) |-> !pad_out[i]);

    assert_feedback_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_fb[i] == pad_in[i]) && (mc_fb[i] == mc_data[i]));
  end
endmodule

bind ioc_top ioc_checker #(.N_PIN(N_PIN)) u_ioc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .prog_mode  (prog_mode),
  .mc_data    (mc_data),
  .pad_in     (pad_in),
  .pin_oe_sel (pin_oe_sel),
  .pin_od     (pin_od),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pin_fb     (pin_fb),
  .mc_fb      (mc_fb),
  .goe_q      (goe_q)
);

// File: tb/ioc_top_bench.sv
`timescale 1ns/1ps
module ioc_top_bench;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            prog_mode = 1'b0;
  logic [1:0]      oe_in = '0;
  logic [NP-1:0]   mc_data = '0;
  logic [17:0]     goe_src_sel = '0;
  logic [5:0]      goe_inv = '0;
  logic [NP*3-1:0] pin_oe_sel = '0;
  logic [NP-1:0]   pin_od = '0;
  logic [NP-1:0]   ext_val = '0;
  logic [NP-1:0]   pad_level;
  logic [NP-1:0]   pad_out, pad_oe, pin_fb, mc_fb;

  int total = 0;
  int bad = 0;
  bit run = 0;
  bit done = 0;
  bit m_goe [6];

  ioc_top #(.N_PIN(NP)) u_ioc_top (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .oe_in(oe_in),
    .mc_data(mc_data), .pad_in(pad_level), .goe_src_sel(goe_src_sel),
    .goe_inv(goe_inv), .pin_oe_sel(pin_oe_sel), .pin_od(pin_od),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_fb(pin_fb), .mc_fb(mc_fb)
  );

  // resolved pad: DUT driver, external driver on input-only pads, weak pull-up otherwise
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      if (pad_oe[i])                      pad_level[i] = pad_out[i];
      else if (pin_oe_sel[i*3 +: 3] == 6) pad_level[i] = ext_val[i];
      else                                pad_level[i] = 1'b1;
    end
  end

  // reference for the global lines (R4, R5)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 6; g++) m_goe[g] <= 1'b0;
    end else begin
      for (int g = 0; g < 6; g++) begin
        int code;
        bit v;
        code = int'(goe_src_sel[g*3 +: 3]);
        case (code)
          0, 1:    v = oe_in[code];
          2, 3:    v = pad_level[code-2];
          4, 5:    v = mc_data[code-4];
          default: v = 1'b0;
        endcase
        m_goe[g] <= v ^ goe_inv[g];
      end
    end
  end

  task automatic cmp(input string tag, input int pin, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s pin %0d: actual=%0b expected=%0b at %0t", tag, pin, act, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < NP; i++) begin
      int s;
      bit en, e_oe, e_out, e_lvl;
      string t;
      s = int'(pin_oe_sel[i*3 +: 3]);
      if (prog_mode)   en = 0;
      else if (s == 6) en = 0;
      else if (s == 7) en = 1;
      else             en = m_goe[s];
      e_oe  = pin_od[i] ? (en & ~mc_data[i]) : en;
      e_out = pin_od[i] ? 1'b0 : mc_data[i];
      e_lvl = e_oe ? e_out : ((s == 6) ? ext_val[i] : 1'b1);
      if (!rst_n && s < 6)  t = "R5";
      else if (prog_mode)   t = "R8";
      else if (s == 6)      t = "R1";
      else if (pin_od[i])   t = "R6";
      else if (s == 7)      t = "R2";
      else                  t = "R3 R4";
      cmp(t, i, pad_oe[i], e_oe);
      cmp(pin_od[i] ? "R6" : "R7", i, pad_out[i], e_out);
      cmp("R9 pin_fb", i, pin_fb[i], e_lvl);
      cmp("R9 mc_fb", i, mc_fb[i], mc_data[i]);
    end
  endtask

  always @(negedge clk) if (run) check_all();

  task automatic rand_inputs();
    oe_in       = 2'($urandom);
    mc_data     = NP'($urandom);
    goe_src_sel = 18'($urandom);
    goe_inv     = 6'($urandom);
    pin_oe_sel  = (NP*3)'($urandom);
    pin_od      = NP'($urandom) & NP'($urandom);
    ext_val     = NP'($urandom);
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R5: reset state, pads selecting global lines stay off
    rand_inputs();
    run = 1;
    for (int k = 0; k < 4; k++) begin
      step(1);
      rand_inputs();
    end
    rst_n = 1'b1;

    // R3 R4 R6 R7 R9: mixed random configurations
    for (int k = 0; k < 400; k++) begin
      rand_inputs();
      step(1);
    end

    // R2 R7: every pad hard on, push-pull
    pin_oe_sel = {NP{3'd7}};
    pin_od = '0;
    for (int k = 0; k < 20; k++) begin
      mc_data = NP'($urandom);
      step(1);
    end

    // R6: hard on with open-drain, high released to pull-up
    pin_od = '1;
    for (int k = 0; k < 20; k++) begin
      mc_data = NP'($urandom);
      step(1);
    end

    // R8: programming mode releases everything
    prog_mode = 1'b1;
    for (int k = 0; k < 20; k++) begin
      rand_inputs();
      step(1);
    end
    prog_mode = 1'b0;

    // R4: constant codes with invert give always-on lines
    goe_src_sel = {6{3'd6}};
    goe_inv = 6'h2A;
    pin_od = '0;
    for (int k = 0; k < NP; k++) pin_oe_sel[k*3 +: 3] = 3'(k % 6);
    for (int k = 0; k < 10; k++) begin
      mc_data = NP'($urandom);
      step(1);
    end

    // R1 R9: all pads input only, external driver read back
    pin_oe_sel = {NP{3'd6}};
    for (int k = 0; k < 20; k++) begin
      ext_val = NP'($urandom);
      mc_data = NP'($urandom);
      step(1);
    end

    // R5: reset asserted mid-run clears global lines
    rst_n = 1'b0;
    goe_inv = '1;
    for (int k = 0; k < NP; k++) pin_oe_sel[k*3 +: 3] = 3'(k % 6);
    step(3);
    rst_n = 1'b1;
    step(5);

    run = 0;
    finish_run();
  end
endmodule